// File: doc/BRIEF.md
# Interrupt Status and Enable Block

This block collects event pulses from the command, data and DMA engines of a card host controller and presents them to software. It holds three 32-bit registers behind a small synchronous register bus. The first is a write-one-to-clear status word. The second is a latch-enable mask that decides which events may record themselves in the status word. The third is a signal-enable mask that decides which recorded bits drive the interrupt line.

Events arrive as single-cycle pulses on two 8-bit vectors, one for normal events and one for errors. The card's own interrupt request arrives as a level. Error bits sit in the upper half of the status word, and a separate summary output rises whenever any error bit is recorded. Both outputs are registered, and they change on the same edge as the status bits that cause them.

Top module: `irq_status_ctrl`

## Requirements
- R1: After a synchronous reset, the status word, latch-enable mask and signal-enable mask all read 0, and `irq_o` and `err_o` are low.
- R2: Each event maps to one status bit: normal event i goes to bit i (i = 0..7), error event i goes to bit 16+i (i = 0..6), and error event 7 goes to bit 28. A pulse sets its bit only when the matching latch-enable bit is 1. When that enable bit is 0, the pulse leaves the status word unchanged.
- R3: Writing to the status word (byte offset 0x30) clears every bit written as 1. Bits written as 0 keep their value.
- R4: If an event pulse and a clearing write hit the same bit on the same edge, the bit ends up set. A clearing write to one bit and an event on another bit, on the same edge, both take effect.
- R5: `irq_o` is high exactly when some status bit is 1 and the same bit of the signal-enable mask is 1. It reflects a status or mask change on the edge that makes that change.
- R6: `err_o` is high exactly when any of status bits 16..22 or bit 28 is 1.
- R7: Only bits 0..8, 16..22 and 28 exist (mask 0x107F01FF). Both enable masks read back what was written, ANDed with that mask, and every other bit of all three registers reads 0.
- R8: Status bit 8 follows the card interrupt level, gated by latch-enable bit 8, with one cycle of delay. Writing 1 to it has no effect while the level is high and enabled.
- R9: The latch-enable mask is at 0x34 and the signal-enable mask is at 0x38. Read data appears one edge after the read request. Any other offset reads 0, and writes there change no register.
- R10: A status bit that is already set stays set when its latch-enable bit is later cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| evt_norm | input | 8 | Normal event pulses, bit i maps to status bit i |
| evt_err | input | 8 | Error event pulses, mapped to status bits 16..22 and 28 |
| card_irq | input | 1 | Card interrupt request level |
| irq_o | output | 1 | Interrupt line |
| err_o | output | 1 | Any error bit recorded |

## Verification
The bench sweeps every pulse-driven status bit one at a time. Each step enables one bit and fires all events at once, so a wrong bit mapping or a leaky enable shows up as extra or missing status bits. It then clears each bit with a write that leaves only that bit at 0, then with a write that holds just that bit. A design that treats zeros as clears, or ignores the ones, fails there.

The collision case fires an event and its own clear on one edge. A design where the clear wins would read 0. Separate checks confirm that the card bit cannot be cleared while its level is high, that a recorded bit survives when its enable is withdrawn, and that writes to an unmapped offset touch nothing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int DW       = 32;
  localparam int N_NORM   = 8;
  localparam int N_ERR    = 8;
  localparam int CARD_BIT = 8;
  localparam int ERR_LO   = 16;
  localparam int ERR_SOLO = 28;

  localparam logic [DW-1:0] CARD_ONEHOT = DW'(1) << CARD_BIT;
  localparam logic [DW-1:0] ERR_MASK    = 32'h107F_0000;
  localparam logic [DW-1:0] IMPL_MASK   = 32'h0000_01FF | ERR_MASK;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_STEN = 2'd2,
    SEL_SGEN = 2'd3
  } reg_sel_e;

  // Place event pulses at their status bit positions.
  function automatic logic [DW-1:0] map_events(input logic [N_NORM-1:0] norm,
                                               input logic [N_ERR-1:0]  errv);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < N_NORM; i++) v[i] = norm[i];
    for (int i = 0; i < N_ERR - 1; i++) v[ERR_LO + i] = errv[i];
    v[ERR_SOLO] = errv[N_ERR-1];
    return v;
  endfunction

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h30,
  parameter logic [ADDR_W-1:0] OFS_STEN = 8'h34,
  parameter logic [ADDR_W-1:0] OFS_SGEN = 8'h38
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_e          sel,
  output logic              we_stat,
  output logic              we_sten,
  output logic              we_sgen
);

  always_comb begin
    if (addr == OFS_STAT)      sel = SEL_STAT;
    else if (addr == OFS_STEN) sel = SEL_STEN;
    else if (addr == OFS_SGEN) sel = SEL_SGEN;
    else                       sel = SEL_NONE;
  end

  assign we_stat = wr && (sel == SEL_STAT);
  assign we_sten = wr && (sel == SEL_STEN);
  assign we_sgen = wr && (sel == SEL_SGEN);

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] d_o,
  output logic [W-1:0] q_o
);

  assign d_o = we ? (wdata & KEEP) : q_o;

  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= d_o;
  end

endmodule

// File: rtl/irqc_status.sv
module irqc_status
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_vec,
  input  logic          card_lvl,
  input  logic [DW-1:0] sten_q,
  input  logic [DW-1:0] sgen_d,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_data,
  output logic [DW-1:0] stat_q,
  output logic          irq_q,
  output logic          err_q
);

  logic [DW-1:0] gated_set;
  logic [DW-1:0] clr_vec;
  logic [DW-1:0] merged;
  logic [DW-1:0] stat_d;
  logic          card_on;

  assign gated_set = set_vec & sten_q;
  assign clr_vec   = clr_we ? clr_data : '0;
  // Set is ORed after the clear so a same-edge event wins.
  assign merged    = (stat_q & ~clr_vec) | gated_set;
  assign card_on   = card_lvl & sten_q[CARD_BIT];
  assign stat_d    = ((merged & ~CARD_ONEHOT) | (card_on ? CARD_ONEHOT : '0)) & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |(stat_d & sgen_d);
      err_q  <= |(stat_d & ERR_MASK);
    end
  end

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irqc_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h30,
  parameter logic [ADDR_W-1:0] OFS_STEN = 8'h34,
  parameter logic [ADDR_W-1:0] OFS_SGEN = 8'h38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [7:0]        evt_norm,
  input  logic [7:0]        evt_err,
  input  logic              card_irq,
  output logic              irq_o,
  output logic              err_o
);

  reg_sel_e      sel;
  logic          we_stat, we_sten, we_sgen;
  logic [DW-1:0] sten_d, sten_q, sgen_d, sgen_q, stat_q;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] rd_mux;

  irqc_decode #(
    .ADDR_W  (ADDR_W),
    .OFS_STAT(OFS_STAT),
    .OFS_STEN(OFS_STEN),
    .OFS_SGEN(OFS_SGEN)
  ) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .sel    (sel),
    .we_stat(we_stat),
    .we_sten(we_sten),
    .we_sgen(we_sgen)
  );

  irqc_mask_reg #(.W(DW), .KEEP(IMPL_MASK)) u_sten (
    .clk  (clk),
    .rst  (rst),
    .we   (we_sten),
    .wdata(bus_wdata),
    .d_o  (sten_d),
    .q_o  (sten_q)
  );

  irqc_mask_reg #(.W(DW), .KEEP(IMPL_MASK)) u_sgen (
    .clk  (clk),
    .rst  (rst),
    .we   (we_sgen),
    .wdata(bus_wdata),
    .d_o  (sgen_d),
    .q_o  (sgen_q)
  );

  assign set_vec = map_events(evt_norm, evt_err);

  irqc_status u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .card_lvl(card_irq),
    .sten_q  (sten_q),
    .sgen_d  (sgen_d),
    .clr_we  (we_stat),
    .clr_data(bus_wdata),
    .stat_q  (stat_q),
    .irq_q   (irq_o),
    .err_q   (err_o)
  );

  always_comb begin
    unique case (sel)
      SEL_STAT: rd_mux = stat_q;
      SEL_STEN: rd_mux = sten_q;
      SEL_SGEN: rd_mux = sgen_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  // sten_d is the next value of the latch mask; expose nothing else from it.
  logic unused_sten_d;
  assign unused_sten_d = ^sten_d;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] OFS_STAT = 8'h30
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic [7:0]        evt_norm,
  input logic              card_irq,
  input logic [31:0]       stat_q,
  input logic [31:0]       sten_q,
  input logic [31:0]       sgen_q,
  input logic              irq_o,
  input logic              err_o
);

  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (evt_norm[0] && sten_q[0]) |=> stat_q[0]); // R2

  AST_DISABLED_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (!sten_q[1] && !stat_q[1]) |=> !stat_q[1]); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_STAT && bus_wdata[2] && !evt_norm[2]) |=> !stat_q[2]); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_STAT && bus_wdata[3] && evt_norm[3] && sten_q[3]) |=> stat_q[3]); // R4

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((stat_q & sgen_q) != '0)); // R5

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    err_o == ((stat_q & ERR_MASK) != '0)); // R6

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((stat_q | sten_q | sgen_q) & ~IMPL_MASK) == '0); // R7

  AST_CARD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !card_irq |=> !stat_q[CARD_BIT]); // R8

endmodule

bind irq_status_ctrl irqc_checker #(.ADDR_W(ADDR_W), .OFS_STAT(OFS_STAT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .evt_norm (evt_norm),
  .card_irq (card_irq),
  .stat_q   (stat_q),
  .sten_q   (sten_q),
  .sgen_q   (sgen_q),
  .irq_o    (irq_o),
  .err_o    (err_o)
);

// File: tb/tb_irq_status_ctrl.sv
module tb_irq_status_ctrl;

  localparam logic [31:0] IMPL = 32'h107F_01FF;
  localparam logic [31:0] ERRM = 32'h107F_0000;
  localparam logic [7:0]  A_ST = 8'h30, A_EN = 8'h34, A_SG = 8'h38, A_XX = 8'h3C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  evt_norm = '0, evt_err = '0;
  logic        card_irq = 1'b0;
  logic        irq_o, err_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_status_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_norm(evt_norm),
    .evt_err(evt_err), .card_irq(card_irq), .irq_o(irq_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic pulse(input logic [7:0] n, input logic [7:0] e);
    @(negedge clk); evt_norm = n; evt_err = e;
    @(negedge clk); evt_norm = '0; evt_err = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_ST, v); chk("R1 status", v, 32'h0);
    rd(A_EN, v); chk("R1 latch-enable", v, 32'h0);
    rd(A_SG, v); chk("R1 signal-enable", v, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 err", {31'b0, err_o}, 32'h0);

    // R7 readback masking
    wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, v); chk("R7 latch-enable mask", v, IMPL);
    wr(A_SG, 32'hFFFF_FFFF); rd(A_SG, v); chk("R7 signal-enable mask", v, IMPL);
    wr(A_EN, 32'h0); wr(A_SG, 32'h0);

    // R9 unmapped offset
    wr(A_XX, 32'hFFFF_FFFF);
    rd(A_XX, v); chk("R9 unmapped read", v, 32'h0);
    rd(A_EN, v); chk("R9 unmapped write leaves latch-enable", v, 32'h0);
    rd(A_SG, v); chk("R9 unmapped write leaves signal-enable", v, 32'h0);

    // R2 nothing latches when disabled
    pulse(8'hFF, 8'hFF);
    rd(A_ST, v); chk("R2 disabled events", v, 32'h0);

    // Sweep all pulse-driven bits
    for (int b = 0; b < 32; b++) begin
      if (IMPL[b] && b != 8) begin
        logic [31:0] one;
        one = 32'h1 << b;
        wr(A_EN, one); wr(A_SG, one);
        pulse(8'hFF, 8'hFF);
        rd(A_ST, v); chk($sformatf("R2 bit %0d latched alone", b), v, one);
        chk($sformatf("R5 irq bit %0d", b), {31'b0, irq_o}, 32'h1);
        chk($sformatf("R6 err bit %0d", b), {31'b0, err_o}, {31'b0, |(one & ERRM)});
        wr(A_SG, 32'h0);
        chk($sformatf("R5 irq masked bit %0d", b), {31'b0, irq_o}, 32'h0);
        wr(A_ST, ~one);
        rd(A_ST, v); chk($sformatf("R3 zeros keep bit %0d", b), v, one);
        wr(A_ST, one);
        rd(A_ST, v); chk($sformatf("R3 one clears bit %0d", b), v, 32'h0);
        chk($sformatf("R6 err cleared bit %0d", b), {31'b0, err_o}, 32'h0);
      end
    end

    // R10 latched bit survives enable removal
    wr(A_EN, 32'h1); pulse(8'h01, 8'h00); wr(A_EN, 32'h0);
    rd(A_ST, v); chk("R10 bit held after disable", v, 32'h1);
    wr(A_ST, 32'h1);

    // R4 same-edge set and clear
    wr(A_EN, 32'h3);
    @(negedge clk); bus_addr = A_ST; bus_wdata = 32'h1; bus_wr = 1'b1; evt_norm = 8'h01;
    @(negedge clk); bus_wr = 1'b0; evt_norm = 8'h00;
    rd(A_ST, v); chk("R4 set wins", v, 32'h1);
    pulse(8'h02, 8'h00);
    @(negedge clk); bus_addr = A_ST; bus_wdata = 32'h2; bus_wr = 1'b1; evt_norm = 8'h01;
    @(negedge clk); bus_wr = 1'b0; evt_norm = 8'h00;
    rd(A_ST, v); chk("R4 clear other bit with set", v, 32'h1);
    wr(A_ST, 32'hFFFF_FFFF);

    // R8 card interrupt level
    wr(A_EN, 32'h0); wr(A_SG, 32'h100);
    @(negedge clk); card_irq = 1'b1;
    rd(A_ST, v); chk("R8 card gated off", v, 32'h0);
    wr(A_EN, 32'h100);
    rd(A_ST, v); chk("R8 card follows level", v, 32'h100);
    chk("R8 card irq", {31'b0, irq_o}, 32'h1);
    wr(A_ST, 32'h100);
    rd(A_ST, v); chk("R8 clear ignored while high", v, 32'h100);
    @(negedge clk); card_irq = 1'b0;
    rd(A_ST, v); chk("R8 card drops with level", v, 32'h0);
    chk("R8 irq drops", {31'b0, irq_o}, 32'h0);

    summary();
  end

endmodule